// File: doc/BRIEF.md
# Memory-Controller Performance Counter Bank

This block is a small bank of performance counters for a memory controller. Counter 0 counts clock cycles and acts as the bank's master timer. Counters 1 to 3 each pick one of several event sources and add that source's per-cycle increment. The increment may be a plain 1 per event or a byte count per transferred beat.

Software drives the bank through a flat word-addressed register port. Each counter has a control word, for enable, a write-one clear, event selection and a read-only overflow flag, and a read-only count word. The cycle counter gates the whole bank. Turning it off, or letting it overflow, halts every counter in the same cycle. Overflow also raises a level interrupt, which stays high until software clears the cycle counter.

A build-time parameter decides what an event counter does when its sum carries out. It can wrap and continue, or stick at all-ones until it is cleared. In both cases it sets a sticky flag and raises no interrupt.

Top module: `pmu_counter_bank`

## Requirements
- R1: After synchronous reset, every control word and every count reads 0 and `irq` is low.
- R2: Control word of counter i is at byte address 4*i. The count of counter i is at 4*(NUM_EVT+1) + 4*i, which is 0x10 with three event counters. Control fields are: bit 0 enable; bit 1 clear (write-one, always reads 0); bits 7:4 event source select; bit 8 overflow flag (read-only). Writes to count addresses have no effect.
- R3: Counter 0 adds 1 on every clock edge while the bank runs.
- R4: An enabled event counter adds the increment of its selected source on every clock edge while the bank runs. A counter whose enable is 0 holds its value.
- R5: The bank runs only while counter 0's enable is 1 and its overflow flag is 0. Otherwise every counter holds, and all of them resume on the same edge.
- R6: When counter 0 counts past all-ones it wraps to 0 and sets its overflow flag. `irq` goes high and the whole bank freezes.
- R7: Clearing counter 0 zeroes its count, clears its overflow flag and drops `irq` on the same edge. Counting resumes on the following edge if enabled.
- R8: An event counter whose sum carries out of CNT_W bits sets its sticky overflow flag. Event overflow never raises `irq`. Reaching exactly all-ones is not an overflow.
- R9: With OVF_MODE = OVF_WRAP, an overflowing event counter keeps the low CNT_W bits of the sum and keeps counting.
- R10: With OVF_MODE = OVF_STOP, an overflowing event counter holds all-ones and ignores increments until it is cleared.
- R11: Clearing an event counter zeroes its count and overflow flag, takes priority over any increment in the same cycle, and lets it count again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (5) | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| src_inc | input | NUM_SRC*INC_W (32) | Per-cycle increment of each event source, source s at bits s*INC_W |
| irq | output | 1 | Level interrupt, high while the cycle counter is in overflow |

## Verification
The embedded properties check on every cycle that the cycle counter steps by one, wraps into the frozen state, and stays frozen while the interrupt is up. They also check that nothing but the cycle counter can raise the interrupt, that clears zero a counter and its flag, and that overflow flags stay sticky. In stop mode they check that a stopped event counter sits at all-ones. Only the bench scenarios show the register map and field layout, and the per-source selection with different increment sizes. They also show the exact boundary where reaching all-ones is not yet an overflow, and how the two overflow modes diverge over the same stimulus once the bank is frozen and later resumed.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int REG_W       = 32;
    localparam int CTL_EN      = 0;
    localparam int CTL_CLR     = 1;
    localparam int CTL_SEL_LSB = 4;
    localparam int SEL_W       = 4;
    localparam int CTL_OVF     = 8;

    typedef enum logic {
        OVF_WRAP = 1'b0,
        OVF_STOP = 1'b1
    } ovf_mode_e;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    function automatic ctl_t ctl_from_word(input logic [REG_W-1:0] w);
        ctl_t c;
        c.en  = w[CTL_EN];
        c.sel = w[CTL_SEL_LSB +: SEL_W];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctl_to_word(input ctl_t c, input logic ovf);
        logic [REG_W-1:0] w;
        w = '0;
        w[CTL_EN]                 = c.en;
        w[CTL_SEL_LSB +: SEL_W]   = c.sel;
        w[CTL_OVF]                = ovf;
        return w;
    endfunction

endpackage

// File: rtl/pmu_reg_file.sv
module pmu_reg_file
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 5
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [REG_W-1:0]               wdata_i,
    output logic [REG_W-1:0]               rdata_o,
    output ctl_t [NUM_CTR-1:0]             ctl_o,
    output logic [NUM_CTR-1:0]             clr_o,
    input  logic [NUM_CTR-1:0][CNT_W-1:0]  cnt_i,
    input  logic [NUM_CTR-1:0]             ovf_i
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    assign word_idx = addr_i[ADDR_W-1:2];

    logic unused_bits;
    assign unused_bits = ^{addr_i[1:0], wdata_i[REG_W-1:CTL_OVF], wdata_i[3:2]};

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctl
        logic hit;
        ctl_t ctl_q;
        assign hit = wr_en_i && (word_idx == IDX_W'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_q <= '0;
            end else if (hit) begin
                ctl_q <= ctl_from_word(wdata_i);
            end
        end
        assign ctl_o[i] = ctl_q;
        assign clr_o[i] = hit && wdata_i[CTL_CLR];
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (word_idx == IDX_W'(i)) begin
                rdata_o = ctl_to_word(ctl_o[i], ovf_i[i]);
            end
            if (word_idx == IDX_W'(i + NUM_CTR)) begin
                rdata_o = REG_W'(cnt_i[i]);
            end
        end
    end

endmodule

// File: rtl/pmu_cycle_ctr.sv
module pmu_cycle_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (en_i && !ovf_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (&cnt_q) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

    AST_CYC_STEP: assert property (@(posedge clk) disable iff (rst)
        en_i && !ovf_q && !clr_i && !(&cnt_q) |=> cnt_q == $past(cnt_q) + 1'b1 && !ovf_q); // R3
    AST_CYC_WRAP: assert property (@(posedge clk) disable iff (rst)
        en_i && !ovf_q && !clr_i && (&cnt_q) |=> ovf_q && cnt_q == '0); // R6
    AST_CYC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ovf_q && !clr_i |=> ovf_q && $stable(cnt_q)); // R6
    AST_CYC_CLR: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> cnt_q == '0 && !ovf_q); // R7

endmodule

// File: rtl/pmu_event_ctr.sv
module pmu_event_ctr
    import pmu_pkg::*;
#(
    parameter int        CNT_W    = 32,
    parameter int        INC_W    = 8,
    parameter ovf_mode_e OVF_MODE = OVF_STOP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [INC_W-1:0] inc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic [CNT_W:0]   sum;
    logic             halted;
    logic [CNT_W-1:0] next_val;

    assign sum = {1'b0, cnt_q} + {{(CNT_W + 1 - INC_W){1'b0}}, inc_i};

    if (OVF_MODE == OVF_STOP) begin : g_stop
        assign halted   = ovf_q;
        assign next_val = sum[CNT_W] ? '1 : sum[CNT_W-1:0];

        AST_STOP_SAT: assert property (@(posedge clk) disable iff (rst)
            ovf_q && !clr_i |=> cnt_q == '1); // R10
    end else begin : g_wrap
        assign halted   = 1'b0;
        assign next_val = sum[CNT_W-1:0];

        AST_WRAP_KEEP: assert property (@(posedge clk) disable iff (rst)
            run_i && !clr_i |=> cnt_q == $past(cnt_q) + CNT_W'($past(inc_i))); // R9
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (run_i && !halted) begin
            cnt_q <= next_val;
            if (sum[CNT_W]) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

    AST_EVT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !run_i && !clr_i |=> $stable(cnt_q) && $stable(ovf_q)); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_q && !clr_i |=> ovf_q); // R8
    AST_EVT_CLR: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> cnt_q == '0 && !ovf_q); // R11

endmodule

// File: rtl/pmu_counter_bank.sv
module pmu_counter_bank
    import pmu_pkg::*;
#(
    parameter int        NUM_EVT  = 3,
    parameter int        CNT_W    = 32,
    parameter int        INC_W    = 8,
    parameter int        NUM_SRC  = 4,
    parameter ovf_mode_e OVF_MODE = OVF_STOP,
    localparam int       NUM_CTR  = NUM_EVT + 1,
    localparam int       ADDR_W   = $clog2(8 * NUM_CTR)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [REG_W-1:0]         reg_wdata,
    output logic [REG_W-1:0]         reg_rdata,
    input  logic [NUM_SRC*INC_W-1:0] src_inc,
    output logic                     irq
);

    ctl_t [NUM_CTR-1:0]            ctl;
    logic [NUM_CTR-1:0]            clr;
    logic [NUM_CTR-1:0][CNT_W-1:0] cnt_all;
    logic [NUM_CTR-1:0]            ovf;
    logic                          bank_run;

    logic unused_sel0;
    assign unused_sel0 = ^ctl[0].sel;

    pmu_reg_file #(
        .NUM_CTR (NUM_CTR),
        .CNT_W   (CNT_W),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .ctl_o   (ctl),
        .clr_o   (clr),
        .cnt_i   (cnt_all),
        .ovf_i   (ovf)
    );

    pmu_cycle_ctr #(
        .CNT_W (CNT_W)
    ) u_cycle (
        .clk   (clk),
        .rst   (rst),
        .en_i  (ctl[0].en),
        .clr_i (clr[0]),
        .cnt_o (cnt_all[0]),
        .ovf_o (ovf[0])
    );

    assign bank_run = ctl[0].en && !ovf[0];
    assign irq      = ovf[0];

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
        logic [INC_W-1:0] inc_sel;
        always_comb begin
            inc_sel = '0;
            for (int s = 0; s < NUM_SRC; s++) begin
                if (ctl[e+1].sel == SEL_W'(s)) begin
                    inc_sel = src_inc[s*INC_W +: INC_W];
                end
            end
        end

        pmu_event_ctr #(
            .CNT_W    (CNT_W),
            .INC_W    (INC_W),
            .OVF_MODE (OVF_MODE)
        ) u_ctr (
            .clk   (clk),
            .rst   (rst),
            .run_i (bank_run && ctl[e+1].en),
            .clr_i (clr[e+1]),
            .inc_i (inc_sel),
            .cnt_o (cnt_all[e+1]),
            .ovf_o (ovf[e+1])
        );
    end

    AST_FREEZE_ALL: assert property (@(posedge clk) disable iff (rst)
        irq && !(|clr) |=> $stable(cnt_all) && irq); // R6
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        !irq && !(ctl[0].en && (&cnt_all[0])) |=> !irq); // R8

endmodule

// File: tb/pmu_counter_bank_tb_top.sv
module pmu_counter_bank_tb_top;
    import pmu_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int IW = 4;
    localparam int NS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [NS*IW-1:0] src_inc = '0;
    logic [31:0] rd_stop, rd_wrap;
    logic        irq_stop, irq_wrap;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmu_counter_bank #(.NUM_EVT(3), .CNT_W(CW), .INC_W(IW), .NUM_SRC(NS), .OVF_MODE(OVF_STOP)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rd_stop), .src_inc(src_inc), .irq(irq_stop));

    pmu_counter_bank #(.NUM_EVT(3), .CNT_W(CW), .INC_W(IW), .NUM_SRC(NS), .OVF_MODE(OVF_WRAP)) dut_wrap_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rd_wrap), .src_inc(src_inc), .irq(irq_wrap));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a,
                          input logic [31:0] exp_s, input logic [31:0] exp_w);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk({tag, " stop"}, rd_stop, exp_s);
        chk({tag, " wrap"}, rd_wrap, exp_w);
    endtask

    // Enables the cycle counter for exactly n counting edges, then disables it.
    task automatic run_bank(input int n);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'h00; reg_wdata = 32'h1;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
        repeat (n - 1) @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'h00; reg_wdata = 32'h0;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic chk_counts(input string tag, input int cy, input int c1, input int c2,
                              input int c3s, input int c3w);
        rd_chk({tag, " R3 cycle"}, 5'h10, cy, cy);
        rd_chk({tag, " R4 ctr1"},  5'h14, c1, c1);
        rd_chk({tag, " R4 ctr2"},  5'h18, c2, c2);
        rd_chk({tag, " R4 ctr3"},  5'h1C, c3s, c3w);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // sources: s0=1, s1=3, s2=5, s3=0
        src_inc = {4'd0, 4'd5, 4'd3, 4'd1};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq stop", 32'(irq_stop), 0);
        chk("R1 irq wrap", 32'(irq_wrap), 0);
        for (int a = 0; a < 8; a++) begin
            rd_chk("R1 reset reg", 5'(a * 4), 0, 0);
        end

        // R2 field layout and read-only counts
        wr(5'h04, 32'h01);
        wr(5'h08, 32'h11);
        wr(5'h0C, 32'h21);
        rd_chk("R2 ctrl2", 5'h08, 32'h11, 32'h11);
        rd_chk("R2 ctrl3", 5'h0C, 32'h21, 32'h21);
        wr(5'h14, 32'hAB);
        rd_chk("R2 count write ignored", 5'h14, 0, 0);
        rd_chk("R5 idle bank holds ctr3", 5'h1C, 0, 0);

        // R3 R4 counting with three increment sizes
        run_bank(20);
        chk_counts("run20", 20, 20, 60, 100, 100);
        // R5 bank stopped: nothing moves
        repeat (5) @(posedge clk);
        chk_counts("R5 hold", 20, 20, 60, 100, 100);

        // R4 disabled counter holds
        wr(5'h08, 32'h10);
        run_bank(10);
        chk_counts("R4 ctr2 off", 30, 30, 60, 150, 150);
        wr(5'h08, 32'h11);

        // R8 reaching all-ones is not an overflow
        run_bank(21);
        chk_counts("R8 at max", 51, 51, 123, 255, 255);
        rd_chk("R8 no ovf flag", 5'h0C, 32'h21, 32'h21);

        // R8 R9 R10 carry out
        run_bank(1);
        chk_counts("R8 carry", 52, 52, 126, 255, 4);
        rd_chk("R8 ovf flag set", 5'h0C, 32'h121, 32'h121);
        chk("R8 no irq stop", 32'(irq_stop), 0);
        chk("R8 no irq wrap", 32'(irq_wrap), 0);
        run_bank(5);
        chk_counts("R10 R9 after ovf", 57, 57, 141, 255, 29);
        rd_chk("R8 sticky", 5'h0C, 32'h121, 32'h121);

        // R11 clear event counter
        wr(5'h0C, 32'h23);
        rd_chk("R11 cleared count", 5'h1C, 0, 0);
        rd_chk("R11 cleared flag", 5'h0C, 32'h21, 32'h21);
        run_bank(4);
        chk_counts("R11 recount", 61, 61, 153, 20, 20);

        // R6 cycle overflow: ctr1 on zero source, ctr2 off, ctr3 on s0
        wr(5'h00, 32'h02);
        wr(5'h04, 32'h31);
        wr(5'h08, 32'h12);
        wr(5'h0C, 32'h03);
        chk_counts("R7 R11 cleared", 0, 61, 0, 0, 0);
        wr(5'h00, 32'h01);
        repeat (260) @(posedge clk);
        #1;
        chk("R6 irq stop", 32'(irq_stop), 1);
        chk("R6 irq wrap", 32'(irq_wrap), 1);
        rd_chk("R6 ctrl0 ovf", 5'h00, 32'h101, 32'h101);
        chk_counts("R6 frozen", 0, 61, 0, 255, 0);
        rd_chk("R8 R6 ctr3 flag", 5'h0C, 32'h101, 32'h101);

        // R7 clear of cycle counter drops irq and lets bank resume
        wr(5'h00, 32'h03);
        chk("R7 irq stop", 32'(irq_stop), 0);
        chk("R7 irq wrap", 32'(irq_wrap), 0);
        wr(5'h00, 32'h00);
        rd_chk("R7 ctrl0", 5'h00, 0, 0);
        chk_counts("R7 resume", 1, 61, 0, 255, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule